// File: doc/BRIEF.md
# Burst Read Mover: Memory to Stream

This block copies a contiguous run of memory words onto a stream. A caller hands it a start byte address and a length in words on a simple valid/ready command port. The block then acts as an AXI4 read master. It cuts the run into incrementing bursts and issues their address requests, and it forwards the returned beats in address order on an AXI4-Stream output. When the last word has left the stream and no burst remains open, it raises a one-cycle completion pulse together with an error indication.

Two processes do the work. The address side issues burst requests. The data side accepts returning beats and matches each RLAST against the length recorded for the oldest open burst. Because the two sides are separate, several bursts can be open at once. An address request is issued only after room for every beat of that burst has been reserved in the output FIFO. The read data channel therefore never has to be throttled, and a stalled stream consumer holds back new requests rather than data already in flight.

Top module: `rd_mover`

## Requirements
- R1: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until the completion pulse, and a command offered while it is low has no effect. Out of reset, `cmd_ready`=1, `m_arvalid`=0, `s_tvalid`=0, `done`=0, and `m_rready` is 1 from the first clock after reset.
- R2: Every address request carries `m_arburst`=2'b01 (incrementing), `m_arsize`=$clog2(DATA_W)-3 (2 for 32-bit data), and `m_arlen` equal to the beat count minus one, with no more than MAX_BEATS beats.
- R3: Each burst's beat count is the smallest of three values: the words remaining, MAX_BEATS, and the words left before the next 4096-byte address boundary. Bursts follow one another at contiguous addresses, so no burst spans a 4096-byte boundary.
- R4: While `m_arvalid` is high and `m_arready` is low, `m_arvalid`, `m_araddr` and `m_arlen` hold their values.
- R5: No more than MAX_OUT bursts are open at once. A burst opens at its address handshake and closes at its RLAST beat. Further requests are issued while earlier bursts are still waiting for data.
- R6: A request is issued only when the output FIFO has free space reserved for all of its beats. A consumer that stops taking data therefore stops further requests once the FIFO is full, and the FIFO never overflows.
- R7: Stream words appear in ascending address order with their data unchanged, for any pattern of stream or read-channel stalls.
- R8: `s_tlast` is high on the final word of the transfer and on no other word.
- R9: `done` is a single-cycle pulse. It is raised once every word has left the stream and no burst is open. A zero-length command issues no request and completes directly.
- R10: `done_err` comes with `done`. It is 1 if any beat of the transfer returned a nonzero RRESP, or an RLAST that did not fall on the recorded final beat, or a beat with no open burst. It is cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Start byte address, aligned to the data width |
| cmd_words | input | LEN_W | Transfer length in words |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error indication, valid with done |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Beats minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type, always incrementing |
| m_arvalid | output | 1 | Address request valid |
| m_arready | input | 1 | Address request accepted |
| m_rdata | input | DATA_W | Read beat data |
| m_rresp | input | 2 | Read beat response |
| m_rlast | input | 1 | Final beat of a burst |
| m_rvalid | input | 1 | Read beat valid |
| m_rready | output | 1 | Read beat accepted |
| s_tdata | output | DATA_W | Stream word |
| s_tlast | output | 1 | Final word of the transfer |
| s_tvalid | output | 1 | Stream word valid |
| s_tready | input | 1 | Stream consumer ready |

## Verification
The bench starts runs a few words short of a 4096-byte boundary, one word short of it, and ending exactly on it. A wrong split shows up as a burst that runs over the boundary or a mismatched `m_arlen`. It holds back read data until the cap on open bursts is reached, and it blocks the consumer until the FIFO fills. A design that ignored the cap, or that reserved no space, would open too many bursts or drop beats. It injects a failed response and an early RLAST. A design that lost the error, or that kept a burst open forever, would report a clean completion or hang. It also sends a zero-length command, and offers a command while the block is busy, which must be ignored.

// File: rtl/rd_mover_pkg.sv
package rd_mover_pkg;
  localparam int PAGE_BYTES = 4096;
  localparam int BEAT_W     = 9;   // holds 1..256 beats

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rd_stream_fifo.sv
module rd_stream_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [AW:0]       cnt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic wr_en, rd_en;

  assign wr_en = push && (cnt != (AW+1)'(DEPTH));
  assign rd_en = pop && (cnt != '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rd_burst_planner.sv
module rd_burst_planner
  import rd_mover_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 16,
  parameter int MAX_OUT   = 4,
  parameter int OW        = $clog2(MAX_OUT+1),
  parameter int CW        = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_words,
  input  logic [OW-1:0]     open_cnt,
  input  logic [CW-1:0]     credit,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic              arvalid,
  output logic [BEAT_W-1:0] ar_beats,
  output logic              reserve,
  output logic [BEAT_W-1:0] reserve_beats,
  output logic              idle
);
  localparam int BYTES      = DATA_W / 8;
  localparam int SHIFT      = $clog2(BYTES);
  localparam int PAGE_WORDS = PAGE_BYTES / BYTES;

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem;
  int room, nb;

  always_comb begin
    room = PAGE_WORDS - int'(cur_addr[11:SHIFT]);
    nb   = min_int(min_int(MAX_BEATS, room), int'(rem));
  end

  assign reserve_beats = BEAT_W'(nb);
  assign reserve = !start && !arvalid && (rem != '0) &&
                   (int'(open_cnt) < MAX_OUT) && (int'(credit) >= nb);
  assign idle = (rem == '0) && !arvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem      <= '0;
      araddr   <= '0;
      arlen    <= '0;
      arvalid  <= 1'b0;
      ar_beats <= '0;
    end else if (start) begin
      cur_addr <= start_addr;
      rem      <= start_words;
    end else begin
      if (arvalid && arready) arvalid <= 1'b0;
      if (reserve) begin
        araddr   <= cur_addr;
        arlen    <= 8'(nb - 1);
        arvalid  <= 1'b1;
        ar_beats <= BEAT_W'(nb);
        cur_addr <= cur_addr + (ADDR_W'(nb) << SHIFT);
        rem      <= rem - LEN_W'(nb);
      end
    end
  end
endmodule

// File: rtl/rd_beat_tracker.sv
module rd_beat_tracker
  import rd_mover_pkg::*;
#(
  parameter int MAX_OUT = 4,
  parameter int OW      = $clog2(MAX_OUT+1),
  parameter int PW      = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BEAT_W-1:0] push_beats,
  input  logic              r_fire,
  input  logic              r_last,
  input  logic [1:0]        r_resp,
  output logic [OW-1:0]     open_cnt,
  output logic              bad
);
  logic [BEAT_W-1:0] q [MAX_OUT];
  logic [PW-1:0]     wp, rp;
  logic [BEAT_W-1:0] idx;
  logic have, exp_last, pop;

  assign have     = (open_cnt != '0);
  assign exp_last = have && ((idx + BEAT_W'(1)) == q[rp]);
  assign pop      = r_fire && r_last && have;
  assign bad      = r_fire && (!have || (r_resp != 2'b00) || (r_last != exp_last));

  always_ff @(posedge clk) begin
    if (push) q[wp] <= push_beats;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      idx      <= '0;
      open_cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(MAX_OUT-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(MAX_OUT-1)) ? '0 : rp + 1'b1;
      if (r_fire) idx <= r_last ? '0 : idx + 1'b1;
      case ({push, pop})
        2'b10:   open_cnt <= open_cnt + 1'b1;
        2'b01:   open_cnt <= open_cnt - 1'b1;
        default: open_cnt <= open_cnt;
      endcase
    end
  end
endmodule

// File: rtl/rd_mover.sv
module rd_mover
  import rd_mover_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BEATS  = 16,
  parameter int MAX_OUT    = 4,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_words,
  output logic              done,
  output logic              done_err,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [DATA_W-1:0] s_tdata,
  output logic              s_tlast,
  output logic              s_tvalid,
  input  logic              s_tready
);
  localparam int OW = $clog2(MAX_OUT+1);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic              busy, err_st, start, finish;
  logic [CW-1:0]     credit;
  logic [LEN_W-1:0]  out_left;
  logic [OW-1:0]     open_cnt;
  logic [CW-1:0]     fifo_cnt;
  logic              fifo_push, pop, trk_bad, reserve, plan_idle;
  logic [BEAT_W-1:0] reserve_beats, ar_beats;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;
  assign m_arsize  = 3'($clog2(DATA_W) - 3);
  assign m_arburst = 2'b01;
  assign fifo_push = m_rvalid && m_rready;
  assign s_tvalid  = (fifo_cnt != '0);
  assign pop       = s_tvalid && s_tready;
  assign s_tlast   = s_tvalid && (out_left == LEN_W'(1));
  assign finish    = busy && plan_idle && (open_cnt == '0) && (fifo_cnt == '0) && !done;

  rd_burst_planner #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS),
    .MAX_OUT(MAX_OUT), .OW(OW), .CW(CW)
  ) u_plan (
    .clk(clk), .rst(rst), .start(start), .start_addr(cmd_addr),
    .start_words(cmd_words), .open_cnt(open_cnt), .credit(credit),
    .arready(m_arready), .araddr(m_araddr), .arlen(m_arlen),
    .arvalid(m_arvalid), .ar_beats(ar_beats), .reserve(reserve),
    .reserve_beats(reserve_beats), .idle(plan_idle)
  );

  rd_beat_tracker #(.MAX_OUT(MAX_OUT), .OW(OW)) u_trk (
    .clk(clk), .rst(rst), .push(m_arvalid && m_arready), .push_beats(ar_beats),
    .r_fire(fifo_push), .r_last(m_rlast), .r_resp(m_rresp),
    .open_cnt(open_cnt), .bad(trk_bad)
  );

  rd_stream_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .din(m_rdata),
    .pop(pop), .dout(s_tdata), .cnt(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      err_st   <= 1'b0;
      out_left <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
      m_rready <= 1'b0;
    end else begin
      m_rready <= 1'b1;
      done     <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        err_st   <= 1'b0;
        out_left <= cmd_words;
      end else begin
        if (trk_bad) err_st <= 1'b1;
        if (pop && out_left != '0) out_left <= out_left - 1'b1;
        if (finish) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          done_err <= err_st || trk_bad;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || finish) credit <= CW'(FIFO_DEPTH);
    else credit <= credit - (reserve ? CW'(reserve_beats) : CW'(0)) + (pop ? CW'(1) : CW'(0));
  end
endmodule

// File: rtl/rd_mover_chk.sv
module rd_mover_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_BEATS  = 16,
  parameter int MAX_OUT    = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int OW         = 3,
  parameter int CW         = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              done,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic [2:0]        m_arsize,
  input logic [1:0]        m_arburst,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              fifo_push,
  input logic [OW-1:0]     open_cnt,
  input logic [CW-1:0]     fifo_cnt
);
  localparam int SHIFT = $clog2(DATA_W/8);

  p_cmd_busy_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready);

  p_ar_fields_r2: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> (m_arburst == 2'b01) && (m_arsize == 3'(SHIFT)) &&
                  (int'(m_arlen) < MAX_BEATS));

  p_no_4k_cross_r3: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> ((16'(m_araddr[11:0]) + ((16'(m_arlen) + 16'd1) << SHIFT)) <= 16'd4096));

  p_ar_stable_r4: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

  p_open_cap_r5: assert property (@(posedge clk) disable iff (rst)
    int'(open_cnt) <= MAX_OUT);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> int'(fifo_cnt) < FIFO_DEPTH);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !m_arvalid && (open_cnt == '0) && (fifo_cnt == '0));
endmodule

bind rd_mover rd_mover_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .MAX_OUT(MAX_OUT),
  .FIFO_DEPTH(FIFO_DEPTH), .OW(OW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .done(done),
  .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .fifo_push(fifo_push),
  .open_cnt(open_cnt), .fifo_cnt(fifo_cnt)
);

// File: tb/rd_mover_test.sv
`timescale 1ns/1ps
module rd_mover_test;
  localparam int MB = 8;
  localparam int MO = 4;
  localparam int FD = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_words = '0;
  logic done, done_err;
  logic [31:0] m_araddr;
  logic [7:0] m_arlen;
  logic [2:0] m_arsize;
  logic [1:0] m_arburst;
  logic m_arvalid, m_rready;
  logic s_arready = 1'b0, s_rvalid = 1'b0, s_rlast = 1'b0;
  logic [31:0] s_rdata = '0;
  logic [1:0] s_rresp = '0;
  logic [31:0] s_tdata;
  logic s_tlast, s_tvalid, k_tready = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rd_mover #(.MAX_BEATS(MB), .MAX_OUT(MO), .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_words(cmd_words), .done(done), .done_err(done_err),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(s_arready), .m_rdata(s_rdata), .m_rresp(s_rresp),
    .m_rlast(s_rlast), .m_rvalid(s_rvalid), .m_rready(m_rready),
    .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(k_tready)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int sink_mode = 0, ar_slow = 0, r_gap = 0, err_mode = 0, r_hold = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a * 32'd7 + 32'h1357;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- memory slave and stream sink ----------------
  logic [31:0] q_addr [16];
  logic [7:0]  q_len  [16];
  int qw = 0, qr = 0, qn = 0, beat = 0, bidx = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (sink_mode)
      0: k_tready <= 1'b1;
      1: k_tready <= (cyc % 3) != 0;
      2: k_tready <= (cyc % 5) < 2;
      default: k_tready <= 1'b0;
    endcase
    if (rst) begin
      s_arready <= 1'b0; s_rvalid <= 1'b0; s_rlast <= 1'b0;
      qw = 0; qr = 0; qn = 0; beat = 0;
    end else begin
      s_arready <= (ar_slow != 0) ? ((cyc % 4) < 2) : 1'b1;
      if (m_arvalid && s_arready) begin
        q_addr[qw] = m_araddr; q_len[qw] = m_arlen; qw = (qw + 1) % 16; qn++;
      end
      if (!s_rvalid || m_rready) begin
        if (qn > 0 && cyc >= r_hold && !(r_gap != 0 && (cyc % 3) == 0)) begin
          automatic bit last;
          last = (err_mode == 2 && bidx == 0) ? (beat == int'(q_len[qr]) - 1)
                                               : (beat == int'(q_len[qr]));
          s_rvalid <= 1'b1;
          s_rdata  <= pat(q_addr[qr] + 32'(beat * 4));
          s_rresp  <= (err_mode == 1 && bidx == 0 && beat == 1) ? 2'b10 : 2'b00;
          s_rlast  <= last;
          if (last) begin beat = 0; bidx++; qr = (qr + 1) % 16; qn--; end
          else beat++;
        end else begin
          s_rvalid <= 1'b0;
        end
      end
    end
  end

  // ---------------- monitor (samples at falling edge) ----------------
  logic [31:0] exp_addr = 0, exp_base = 0;
  int exp_rem = 0, exp_words = 0;
  int ar_cnt = 0, word_cnt = 0, tlast_cnt = 0, done_cnt = 0, open_now = 0, peak = 0;
  bit last_err = 0, prev_done = 0, prev_hold = 0;
  logic [31:0] prev_addr = 0;
  logic [7:0] prev_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_hold) begin
        chk(m_arvalid, "R4", "arvalid held", m_arvalid, 1);
        chk(m_araddr == prev_addr && m_arlen == prev_len, "R4", "araddr held",
            m_araddr, prev_addr);
      end
      prev_hold = m_arvalid && !s_arready;
      prev_addr = m_araddr; prev_len = m_arlen;
      if (m_arvalid && s_arready) begin
        automatic int room = (4096 - int'(exp_addr % 4096)) / 4;
        automatic int nb = MB;
        if (room < nb) nb = room;
        if (exp_rem < nb) nb = exp_rem;
        chk(exp_rem > 0, "R9", "request with nothing left", exp_rem, 1);
        chk(m_araddr == exp_addr, "R3", "burst address", m_araddr, exp_addr);
        chk(int'(m_arlen) == nb - 1, "R2", "arlen", m_arlen, nb - 1);
        chk(m_arburst == 2'b01 && m_arsize == 3'd2, "R2", "burst/size",
            {m_arburst, m_arsize}, 5'b01010);
        exp_addr += 32'(nb * 4); exp_rem -= nb; ar_cnt++; open_now++;
      end
      if (s_rvalid && m_rready && s_rlast) open_now--;
      if (open_now > peak) peak = open_now;
      if (s_tvalid && k_tready) begin
        chk(s_tdata == pat(exp_base + 32'(word_cnt * 4)), "R7", "stream data",
            s_tdata, pat(exp_base + 32'(word_cnt * 4)));
        chk(s_tlast == (word_cnt == exp_words - 1), "R8", "tlast", s_tlast,
            word_cnt == exp_words - 1);
        if (s_tlast) tlast_cnt++;
        word_cnt++;
      end
      if (done) begin
        chk(!prev_done, "R9", "done single cycle", prev_done, 0);
        done_cnt++; last_err = done_err;
      end
      prev_done = done;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [31:0] a, input int w);
    @(posedge clk);
    exp_addr = a; exp_base = a; exp_rem = w; exp_words = w;
    ar_cnt = 0; word_cnt = 0; tlast_cnt = 0; peak = 0; open_now = 0; bidx = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_words = 16'(w);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "cmd_ready low while busy", cmd_ready, 0);
  endtask

  task automatic wait_done(input int limit);
    automatic int s = done_cnt;
    for (int i = 0; i < limit && done_cnt == s; i++) @(posedge clk);
    chk(done_cnt != s, "R9", "done seen", done_cnt - s, 1);
  endtask

  // {addr[31:0], words[15:0], bursts[7:0], stall[1:0]}
  localparam logic [57:0] VEC [7] = '{
    {32'h0000_0000, 16'd1,  8'd1, 2'd0},
    {32'h0000_0100, 16'd40, 8'd5, 2'd0},
    {32'h0000_0FF0, 16'd10, 8'd2, 2'd1},
    {32'h0000_1FE0, 16'd8,  8'd1, 2'd0},
    {32'h0000_2FF8, 16'd20, 8'd4, 2'd1},
    {32'h0000_3004, 16'd30, 8'd4, 2'd2},
    {32'h0000_0FFC, 16'd3,  8'd2, 2'd2}
  };

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !m_arvalid && !s_tvalid && !done, "R1", "reset outputs",
        {cmd_ready, m_arvalid, s_tvalid, done}, 4'b1000);
    chk(m_rready, "R1", "rready after reset", m_rready, 1);

    // table walk
    foreach (VEC[i]) begin
      sink_mode = int'(VEC[i][1:0]);
      r_gap = (VEC[i][1:0] != 0) ? 1 : 0;
      ar_slow = i % 2;
      send(VEC[i][57:26], int'(VEC[i][25:10]));
      wait_done(3000);
      chk(word_cnt == int'(VEC[i][25:10]), "R7", "word count", word_cnt, VEC[i][25:10]);
      chk(ar_cnt == int'(VEC[i][9:2]), "R3", "burst count", ar_cnt, VEC[i][9:2]);
      chk(tlast_cnt == 1, "R8", "one tlast", tlast_cnt, 1);
      chk(!last_err, "R10", "clean run error", last_err, 0);
    end
    sink_mode = 0; r_gap = 0; ar_slow = 0;

    // R5: hold data back, cap open bursts; a command offered while busy is ignored (R1)
    r_hold = cyc + 80;
    send(32'h5000, 64);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = 32'hF000; cmd_words = 16'd7;
      chk(!cmd_ready, "R1", "busy refuses command", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    wait_done(3000);
    chk(peak == MO, "R5", "peak open bursts", peak, MO);
    chk(ar_cnt == 8, "R5", "bursts after hold", ar_cnt, 8);
    chk(word_cnt == 64, "R7", "words after hold", word_cnt, 64);

    // R6: blocked consumer stops requests once FIFO is reserved full
    sink_mode = 3;
    send(32'h4000, 100);
    repeat (300) @(posedge clk);
    chk(ar_cnt == FD / MB, "R6", "requests while sink blocked", ar_cnt, FD / MB);
    chk(word_cnt == 0, "R6", "no words while blocked", word_cnt, 0);
    sink_mode = 0;
    wait_done(5000);
    chk(word_cnt == 100, "R6", "no beats lost", word_cnt, 100);
    chk(ar_cnt == 13, "R3", "bursts for 100 words", ar_cnt, 13);

    // R9: zero-length command
    send(32'h9000, 0);
    wait_done(100);
    chk(ar_cnt == 0 && word_cnt == 0, "R9", "zero length traffic", ar_cnt + word_cnt, 0);
    chk(!last_err, "R9", "zero length error", last_err, 0);

    // R10: failed response
    err_mode = 1;
    send(32'h6000, 16);
    wait_done(2000);
    chk(last_err, "R10", "bad response flagged", last_err, 1);
    chk(word_cnt == 16, "R10", "words with bad response", word_cnt, 16);

    // R10: early RLAST
    err_mode = 2;
    send(32'h7000, 4);
    wait_done(2000);
    chk(last_err, "R10", "early rlast flagged", last_err, 1);
    chk(word_cnt == 3, "R10", "words with early rlast", word_cnt, 3);

    // R10: sticky flag cleared by next command
    err_mode = 0;
    send(32'h8000, 5);
    wait_done(2000);
    chk(!last_err, "R10", "error cleared", last_err, 0);
    chk(word_cnt == 5 && tlast_cnt == 1, "R8", "recovery run", word_cnt, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule